// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, grouped into banks of 32, and presents one interrupt request to a processor. Each bank carries a mask word that software can load whole or change bit by bit. One alias enables sources and a second alias disables them. Each bank also exposes a read-only word of the sources that are both asserted and enabled.

The controller picks one active interrupt, the lowest-numbered enabled source that is asserted, and holds it. A sorted-number register reports it until software acknowledges it through a control register. After the acknowledge, the next active source is chosen. An acknowledge also drops a held interrupt whose line has since gone low or been masked. A soft reset, started from the system configuration register, puts every register back to its reset value and raises a sticky completion flag. The block also stores a few configuration words and one priority-level byte per source for software context save and restore. It does not act on them.

All registers sit on a simple 32-bit bus. A write is taken on the clock edge while `wrEn` is high. Read data is combinational from `addr`.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After hardware reset, every bank mask word reads 0xFFFFFFFF. The pending words, sorted number (0x40), system status (0x14), configuration words and level bytes all read 0, and `cpuIrq` is low.
- R2: Offset 0x00 reads the fixed identifier: major version in bits 7:4 and minor version in bits 3:0, 0x21 by default. Writes to it change nothing.
- R3: Writing to the enable alias of bank b (0x88 + 0x20·b) clears each mask bit whose written bit is 1. Mask bits whose written bit is 0 keep their value.
- R4: Writing to the disable alias of bank b (0x8C + 0x20·b) sets each mask bit whose written bit is 1. Mask bits whose written bit is 0 keep their value.
- R5: The mask word of bank b sits at 0x84 + 0x20·b, is written whole and reads back; bit i of bank b masks source 32·b + i.
- R6: The pending word of bank b (0x98 + 0x20·b) reads the source inputs AND NOT the mask bits of that bank, live. Writes to it are ignored.
- R7: Only while no interrupt is held, the lowest-numbered pending source is captured on the next edge. Its number then reads in bits 6:0 of 0x40, and `cpuIrq` is high while an interrupt is held. Offset 0x40 reads 0 when nothing is held.
- R8: A held interrupt stays unchanged when other sources assert, when its line drops, or when it is masked. Writing a value with bit 0 = 1 to 0x48 releases it on that edge, and a new capture can follow on the next edge. A write to 0x48 with bit 0 = 0 has no effect.
- R9: Writing offset 0x10 with bit 1 = 1 returns every register to its R1 value on that edge, except bit 0 of 0x14. That bit reads 1 from the next cycle and stays 1 until hardware reset. Bit 1 of 0x10 always reads 0.
- R10: Configuration bits read back as written: 0x10 bit 0 (automatic idle), 0x4C bit 0, 0x50 bits 1:0 and 0x68 bits 7:0. Other bits of these words read 0.
- R11: The level byte of source i sits at 0x100 + 4·i for i below the source count. It stores bits 7:0 of the written data and reads them back.
- R12: Offsets that decode to no register, including unaligned level offsets and level offsets at or beyond the source count, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Active-low synchronous hardware reset |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 10 | Byte offset of the accessed register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqIn | input | 128 | Level-sensitive source lines, bit i is source i |
| cpuIrq | output | 1 | High while an interrupt is held |

## Verification
The properties assume that a write strobe always comes with a stable, defined address and data, and that the source lines only change between clock edges. The bench drives all bus and source inputs on the falling edge, so every rising edge sees settled values. The hold property also assumes that an acknowledge and a soft reset never arrive on the same edge, which the decode guarantees because they live at different offsets. The bench never issues them together: directed steps cover capture, masking while held, acknowledge and soft reset one at a time. A random phase then mixes legal writes and source patterns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int BANK_SIZE  = 32;
  localparam int MAX_SRC    = 128;
  localparam int SRC_IDX_W  = $clog2(MAX_SRC);
  localparam int BANK_IDX_W = $clog2(MAX_SRC / BANK_SIZE);

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_REV,
    SEL_SYSCFG,
    SEL_SYSSTAT,
    SEL_SORTED,
    SEL_CTRL,
    SEL_PROT,
    SEL_IDLE,
    SEL_THR,
    SEL_MASK,
    SEL_MCLR,
    SEL_MSET,
    SEL_PEND,
    SEL_LVL
  } regSel_e;

  typedef struct packed {
    regSel_e               sel;
    logic [BANK_IDX_W-1:0] bank;
    logic [SRC_IDX_W-1:0]  lvlIdx;
    logic                  wrStb;
    logic                  ackStb;
    logic                  softRstStb;
  } busCmd_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output busCmd_t           cmd
);

  localparam int NUM_BANKS = (NUM_SRC + BANK_SIZE - 1) / BANK_SIZE;
  localparam int LVL_BASE  = 'h100;
  localparam int BANK_BASE = 'h80;

  regSel_e sel;
  logic [BANK_IDX_W-1:0] bankSel;
  logic [SRC_IDX_W-1:0]  lvlSel;

  always_comb begin
    int addrInt;
    int bankInt;
    int offInt;
    int idxInt;
    addrInt = int'(addr);
    bankInt = (addrInt - BANK_BASE) / BANK_SIZE;
    offInt  = (addrInt - BANK_BASE) % BANK_SIZE;
    idxInt  = (addrInt - LVL_BASE) / 4;
    sel     = SEL_NONE;
    bankSel = '0;
    lvlSel  = '0;
    case (addrInt)
      'h000:   sel = SEL_REV;
      'h010:   sel = SEL_SYSCFG;
      'h014:   sel = SEL_SYSSTAT;
      'h040:   sel = SEL_SORTED;
      'h048:   sel = SEL_CTRL;
      'h04C:   sel = SEL_PROT;
      'h050:   sel = SEL_IDLE;
      'h068:   sel = SEL_THR;
      default: sel = SEL_NONE;
    endcase
    if (addrInt >= BANK_BASE && addrInt < LVL_BASE && bankInt < NUM_BANKS) begin
      bankSel = BANK_IDX_W'(bankInt);
      case (offInt)
        'h04:    sel = SEL_MASK;
        'h08:    sel = SEL_MCLR;
        'h0C:    sel = SEL_MSET;
        'h18:    sel = SEL_PEND;
        default: sel = SEL_NONE;
      endcase
    end
    if (addrInt >= LVL_BASE && (addrInt % 4) == 0 && idxInt < NUM_SRC) begin
      sel    = SEL_LVL;
      lvlSel = SRC_IDX_W'(idxInt);
    end
  end

  always_comb begin
    cmd            = '0;
    cmd.sel        = sel;
    cmd.bank       = bankSel;
    cmd.lvlIdx     = lvlSel;
    cmd.wrStb      = wrEn && (sel != SEL_NONE);
    cmd.ackStb     = wrEn && (sel == SEL_CTRL) && wrData[0];
    cmd.softRstStb = wrEn && (sel == SEL_SYSCFG) && wrData[1];
  end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int DATA_W    = 32,
  parameter int LVL_W     = 8,
  parameter int THR_W     = 8,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  busCmd_t            cmd,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  rdData,
  output logic               cpuIrq
);

  localparam int NUM_BANKS = (NUM_SRC + BANK_SIZE - 1) / BANK_SIZE;
  localparam int PAD_W     = NUM_BANKS * BANK_SIZE;

  logic [BANK_SIZE-1:0] maskBank [NUM_BANKS];
  logic [BANK_SIZE-1:0] pendBank [NUM_BANKS];
  logic [PAD_W-1:0]     maskFlat;
  logic [PAD_W-1:0]     rawPad;
  logic [PAD_W-1:0]     pendFlat;
  logic                 pendAny;
  logic [SRC_IDX_W-1:0] lowIdx;

  logic                 activeValid;
  logic [SRC_IDX_W-1:0] activeNum;

  logic                 autoIdle;
  logic                 protBit;
  logic [1:0]           idleCfg;
  logic [THR_W-1:0]     thrVal;
  logic                 resetDone;
  logic [LVL_W-1:0]     lvlReg [NUM_SRC];

  logic [BANK_SIZE-1:0] bankWord;
  logic                 wrMask, wrClr, wrSet, wrLvl;

  assign bankWord = wrData[BANK_SIZE-1:0];
  assign wrMask   = cmd.wrStb && (cmd.sel == SEL_MASK);
  assign wrClr    = cmd.wrStb && (cmd.sel == SEL_MCLR);
  assign wrSet    = cmd.wrStb && (cmd.sel == SEL_MSET);
  assign wrLvl    = cmd.wrStb && (cmd.sel == SEL_LVL);

  generate
    if (PAD_W > NUM_SRC) begin : g_padRaw
      assign rawPad = {{(PAD_W - NUM_SRC){1'b0}}, irqIn};
    end else begin : g_fullRaw
      assign rawPad = irqIn;
    end
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign maskFlat[b*BANK_SIZE +: BANK_SIZE] = maskBank[b];
      assign pendBank[b] = pendFlat[b*BANK_SIZE +: BANK_SIZE];
    end
  endgenerate

  assign pendFlat = rawPad & ~maskFlat;
  assign pendAny  = |pendFlat;

  always_comb begin
    lowIdx = '0;
    for (int i = PAD_W - 1; i >= 0; i--) begin
      if (pendFlat[i]) lowIdx = SRC_IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!rstN || cmd.softRstStb) begin
        maskBank[b] <= '1;
      end else if (int'(cmd.bank) == b) begin
        if (wrMask)     maskBank[b] <= bankWord;
        else if (wrClr) maskBank[b] <= maskBank[b] & ~bankWord;
        else if (wrSet) maskBank[b] <= maskBank[b] | bankWord;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.softRstStb) begin
      activeValid <= 1'b0;
      activeNum   <= '0;
    end else if (cmd.ackStb) begin
      activeValid <= 1'b0;
    end else if (!activeValid && pendAny) begin
      activeValid <= 1'b1;
      activeNum   <= lowIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.softRstStb) begin
      autoIdle <= 1'b0;
      protBit  <= 1'b0;
      idleCfg  <= '0;
      thrVal   <= '0;
    end else if (cmd.wrStb) begin
      case (cmd.sel)
        SEL_SYSCFG: autoIdle <= wrData[0];
        SEL_PROT:   protBit  <= wrData[0];
        SEL_IDLE:   idleCfg  <= wrData[1:0];
        SEL_THR:    thrVal   <= wrData[THR_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               resetDone <= 1'b0;
    else if (cmd.softRstStb) resetDone <= 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!rstN || cmd.softRstStb)                   lvlReg[i] <= '0;
      else if (wrLvl && int'(cmd.lvlIdx) == i)       lvlReg[i] <= wrData[LVL_W-1:0];
    end
  end

  always_comb begin
    rdData = '0;
    case (cmd.sel)
      SEL_REV:     rdData[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
      SEL_SYSCFG:  rdData[0] = autoIdle;
      SEL_SYSSTAT: rdData[0] = resetDone;
      SEL_SORTED:  rdData[SRC_IDX_W-1:0] = activeValid ? activeNum : '0;
      SEL_PROT:    rdData[0] = protBit;
      SEL_IDLE:    rdData[1:0] = idleCfg;
      SEL_THR:     rdData[THR_W-1:0] = thrVal;
      SEL_MASK:    rdData[BANK_SIZE-1:0] = maskBank[cmd.bank];
      SEL_PEND:    rdData[BANK_SIZE-1:0] = pendBank[cmd.bank];
      SEL_LVL:     rdData[LVL_W-1:0] = lvlReg[cmd.lvlIdx];
      default:     rdData = '0;
    endcase
  end

  assign cpuIrq = activeValid;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (activeValid && !cmd.ackStb && !cmd.softRstStb) |=> (activeValid && $stable(activeNum))); // R8

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.ackStb |=> !activeValid); // R8

  AST_CAPTURE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(activeValid) |-> $past(pendAny)); // R7

  AST_SOFT_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.softRstStb |=> (resetDone && (&maskFlat) && !activeValid && !autoIdle)); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |=> resetDone); // R9

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int LVL_W     = 8,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               cpuIrq
);

  busCmd_t cmd;

  irqc_decode #(
    .NUM_SRC(NUM_SRC),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_decode (
    .addr  (addr),
    .wrEn  (wrEn),
    .wrData(wrData),
    .cmd   (cmd)
  );

  irqc_regs #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .LVL_W    (LVL_W),
    .THR_W    (8),
    .REV_MAJOR(REV_MAJOR),
    .REV_MINOR(REV_MINOR)
  ) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .wrData(wrData),
    .irqIn (irqIn),
    .rdData(rdData),
    .cpuIrq(cpuIrq)
  );

endmodule

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;

  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [9:0]   addr = '0;
  logic [31:0]  wrData = '0;
  logic [31:0]  rdData;
  logic [127:0] irqIn = '0;
  logic         cpuIrq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  bit [127:0] mMask;
  bit         mValid;
  int         mNum;
  bit         mAuto, mProt, mDone;
  bit [1:0]   mIdle;
  bit [7:0]   mThr;
  bit [7:0]   mLvl [128];

  irq_bank_ctrl u_irq_bank_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .cpuIrq(cpuIrq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic modelClear();
    mMask = '1; mValid = 0; mNum = 0; mAuto = 0; mProt = 0; mIdle = 0; mThr = 0;
    for (int i = 0; i < 128; i++) mLvl[i] = 0;
  endtask

  always @(posedge clk) begin
    bit [127:0] pend;
    bit ack;
    int a, b, o;
    pend = irqIn & ~mMask;
    ack = 0;
    a = int'(addr);
    if (!rstN) begin
      modelClear();
      mDone = 0;
    end else if (wrEn && a == 'h10 && wrData[1]) begin
      modelClear();
      mDone = 1;
    end else begin
      if (wrEn) begin
        if (a == 'h10) mAuto = wrData[0];
        if (a == 'h48 && wrData[0]) ack = 1;
        if (a == 'h4C) mProt = wrData[0];
        if (a == 'h50) mIdle = wrData[1:0];
        if (a == 'h68) mThr = wrData[7:0];
        if (a >= 'h80 && a < 'h100) begin
          b = (a - 'h80) / 32; o = (a - 'h80) % 32;
          if (o == 4)  mMask[b*32 +: 32] = wrData;
          if (o == 8)  mMask[b*32 +: 32] = mMask[b*32 +: 32] & ~wrData;
          if (o == 12) mMask[b*32 +: 32] = mMask[b*32 +: 32] | wrData;
        end
        if (a >= 'h100 && a < 'h300 && a % 4 == 0) mLvl[(a - 'h100) / 4] = wrData[7:0];
      end
      if (ack) mValid = 0;
      else if (!mValid && pend != 0) begin
        for (int i = 127; i >= 0; i--) if (pend[i]) mNum = i;
        mValid = 1;
      end
    end
  end

  function automatic logic [31:0] expRead(int a);
    bit [127:0] pend;
    int b, o;
    pend = irqIn & ~mMask;
    if (a == 'h00) return 32'h21;
    if (a == 'h10) return {31'b0, mAuto};
    if (a == 'h14) return {31'b0, mDone};
    if (a == 'h40) return mValid ? mNum : 0;
    if (a == 'h4C) return {31'b0, mProt};
    if (a == 'h50) return {30'b0, mIdle};
    if (a == 'h68) return {24'b0, mThr};
    if (a >= 'h80 && a < 'h100) begin
      b = (a - 'h80) / 32; o = (a - 'h80) % 32;
      if (o == 4)  return mMask[b*32 +: 32];
      if (o == 24) return pend[b*32 +: 32];
      return 0;
    end
    if (a >= 'h100 && a < 'h300 && a % 4 == 0) return {24'b0, mLvl[(a - 'h100) / 4]};
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // cpuIrq against the model on every clock, sampled away from the rising edge
  always @(negedge clk) begin
    if (rstN && !finished) check("R7 cpuIrq", {31'b0, cpuIrq}, {31'b0, mValid});
  end

  task automatic busWrite(int a, logic [31:0] d);
    @(negedge clk);
    addr = 10'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busCheck(string req, int a);
    @(negedge clk);
    addr = 10'(a); wrEn = 1'b0;
    #1;
    check(req, rdData, expRead(a));
  endtask

  task automatic busCheckVal(string req, int a, logic [31:0] exp);
    @(negedge clk);
    addr = 10'(a); wrEn = 1'b0;
    #1;
    check(req, rdData, exp);
    check(req, expRead(a), exp);
  endtask

  task automatic finish();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int b = 0; b < 4; b++) busCheckVal("R1 mask reset", 'h84 + 32*b, 32'hFFFF_FFFF);
    busCheckVal("R1 pending reset", 'h98, 0);
    busCheckVal("R1 sorted reset", 'h40, 0);
    busCheckVal("R1 status reset", 'h14, 0);
    busCheckVal("R1 level reset", 'h100, 0);
    check("R1 cpuIrq reset", {31'b0, cpuIrq}, 0);
    // R2 identifier, read-only
    busCheckVal("R2 revision", 'h00, 32'h21);
    busWrite('h00, 32'hFFFF_FFFF);
    busCheckVal("R2 revision after write", 'h00, 32'h21);
    // R6 all masked: nothing pending
    irqIn = 128'h0;
    irqIn[5] = 1; irqIn[7] = 1;
    busCheckVal("R6 masked pending", 'h98, 0);
    // R3 enable alias
    busWrite('h88, 32'h0000_00F0);
    busCheckVal("R3 mask after clear", 'h84, 32'hFFFF_FF0F);
    busCheckVal("R6 pending", 'h98, 32'h0000_00A0);
    busCheckVal("R7 sorted lowest", 'h40, 5);
    // R7 lower source arriving later does not displace
    busWrite('h88, 32'h0000_0010);
    irqIn[4] = 1;
    busCheckVal("R7 held despite lower", 'h40, 5);
    // R4 disable alias and R8 hold while masked/deasserted
    busWrite('h8C, 32'h0000_0020);
    busCheckVal("R4 mask after set", 'h84, 32'hFFFF_FF2F);
    irqIn[5] = 0;
    busCheckVal("R8 held after mask", 'h40, 5);
    busWrite('h48, 32'h2);
    busCheckVal("R8 ack bit0 zero ignored", 'h40, 5);
    busWrite('h48, 32'h1);
    busCheckVal("R8 after ack", 'h40, 4);
    // R5 direct mask load in bank 3, source 100
    busWrite('h48, 32'h1);
    irqIn = '0; irqIn[100] = 1;
    busWrite('h88, 32'hFFFF_FFFF);
    busWrite('hE4, 32'hFFFF_FFEF);
    busCheckVal("R5 bank3 mask", 'hE4, 32'hFFFF_FFEF);
    busCheckVal("R7 sorted bank3", 'h40, 100);
    busWrite('hF8, 32'h0);
    busCheckVal("R6 pending write ignored", 'hF8, 32'h0000_0010);
    // R10 configuration words
    busWrite('h10, 32'hFFFF_FFFD);
    busWrite('h4C, 32'hFFFF_FFFF);
    busWrite('h50, 32'hFFFF_FFFE);
    busWrite('h68, 32'h0000_01A5);
    busCheckVal("R10 autoidle", 'h10, 1);
    busCheckVal("R10 protection", 'h4C, 1);
    busCheckVal("R10 idle", 'h50, 2);
    busCheckVal("R10 threshold", 'h68, 32'hA5);
    // R11 level bytes
    busWrite('h100, 32'h1234_5678);
    busWrite('h2FC, 32'h0000_00C3);
    busCheckVal("R11 level 0", 'h100, 32'h78);
    busCheckVal("R11 level 127", 'h2FC, 32'hC3);
    // R12 unimplemented
    busWrite('h300, 32'hFF);
    busWrite('h101, 32'hFF);
    busCheckVal("R12 beyond levels", 'h300, 0);
    busCheckVal("R12 unaligned", 'h101, 0);
    busCheckVal("R12 hole", 'h20, 0);
    busCheckVal("R12 alias reads zero", 'h88, 0);
    // R9 soft reset
    busWrite('h10, 32'h3);
    busCheckVal("R9 status done", 'h14, 1);
    busCheckVal("R9 sysconfig cleared", 'h10, 0);
    busCheckVal("R9 mask restored", 'hE4, 32'hFFFF_FFFF);
    busCheckVal("R9 level restored", 'h2FC, 0);
    busCheckVal("R9 sorted cleared", 'h40, 0);
    check("R9 cpuIrq cleared", {31'b0, cpuIrq}, 0);
    // random mix against the reference model
    for (int n = 0; n < 400; n++) begin
      int sel;
      int a;
      sel = int'($urandom_range(0, 11));
      if ($urandom_range(0, 3) == 0)
        irqIn = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      case (sel)
        0: a = 'h48;
        1: a = 'h88 + 32 * int'($urandom_range(0, 3));
        2: a = 'h8C + 32 * int'($urandom_range(0, 3));
        3: a = 'h84 + 32 * int'($urandom_range(0, 3));
        4: a = 'h100 + 4 * int'($urandom_range(0, 127));
        5: a = 'h4C;
        6: a = 'h10;
        default: a = -1;
      endcase
      if (a >= 0) begin
        logic [31:0] d;
        d = $urandom;
        if (a == 'h10 && $urandom_range(0, 15) != 0) d[1] = 1'b0;
        busWrite(a, d);
      end
      busCheck("R7 random sorted", 'h40);
      busCheck("R6 random pending", 'h98 + 32 * int'($urandom_range(0, 3)));
      busCheck("R5 random mask", 'h84 + 32 * int'($urandom_range(0, 3)));
    end
    busCheck("R9 random status", 'h14);
    finish();
  end

endmodule